// File: doc/BRIEF.md
# Stack Machine ALU

This block is the arithmetic core of a zero-operand stack processor. It holds a small hardware operand stack of 32-bit words. On a cycle with a valid opcode it takes its operands from the top of that stack, computes a result and writes it back in place, all within one clock edge. A separate push port loads literal words onto the stack. The word on top and the current depth are always visible on the outputs.

The operation set covers addition, subtraction, bitwise logic, negation and inversion, equality and ordered compares, a 16x16 unsigned multiply, left and arithmetic-right shifts, bit reversal and halfword swap. For two-operand operations, the word on top is called `a` and the word beneath it is called `b`. Both are consumed and one result is left in their place. One-operand operations rewrite the top word in place.

Stack misuse never corrupts the stored words. An operation that lacks operands, or a push onto a full stack, leaves the stack as it was and sets an error flag. That flag stays set until reset.

Top module: `stk_alu`

## Requirements
- R1: After reset the depth is 0, both error flags are 0, and the top-of-stack output reads 0. Whenever the stack is empty, the top-of-stack output reads 0.
- R2: A push on a stack that is not full places the pushed word on top and raises the depth by one. If a push and an opcode arrive in the same cycle, the push is taken and the opcode is dropped.
- R3: A push onto a full stack (depth equal to the DEPTH parameter) leaves depth and contents unchanged and sets the overflow flag. The overflow flag stays at 1 until reset.
- R4: Opcodes 0x05 (sum, modulo 2^32), 0x06 (AND), 0x07 (OR) and 0x32 (XOR) replace `a` and `b` with one result, so the depth drops by one.
- R5: Opcode 0x31 replaces `a` and `b` with `b - a`, modulo 2^32.
- R6: Opcode 0x09 replaces the top word with its bitwise inverse. Opcode 0x30 replaces it with its two's-complement negation. The depth is unchanged.
- R7: Opcode 0x0A replaces the top word with its bit reversal, where bit j moves to bit 31-j. Opcode 0x28 exchanges the upper and lower 16-bit halves of the top word.
- R8: Opcode 0x2E leaves 1 if `a` equals `b`, else 0. Opcode 0x2F leaves 1 if they differ, else 0.
- R9: Opcode 0x24 leaves 1 if `a < b` as signed numbers, and 0x25 leaves 1 if `a <= b` as signed numbers. Opcodes 0x26 and 0x27 are the same two tests on unsigned values.
- R10: Opcode 0x3E leaves the 32-bit unsigned product of the low 16 bits of `a` and of `b`.
- R11: Opcode 0x2B shifts `b` left by `a[5:0]`. Opcode 0x2C shifts `b` right arithmetically by `a[5:0]`. The upper bits of `a` are ignored. A count of 32 to 63 gives 0 for the left shift and a word filled with the sign bit for the right shift.
- R12: A two-operand opcode with depth below 2, or a one-operand opcode with depth 0, leaves depth and contents unchanged and sets the underflow flag. The underflow flag stays at 1 until reset.
- R13: Opcode 0x0B, and every opcode not named in R4 to R11, leaves depth, contents and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode |
| push_valid | input | 1 | Literal push strobe |
| push_data | input | 32 | Literal word to push |
| tos | output | 32 | Word on top of the stack, 0 when the stack is empty |
| depth | output | $clog2(DEPTH+1) | Number of words on the stack |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DEPTH set to 4. At that size the full-stack boundary is reached after four pushes, so the overflow case and its sticky flag can be tested. The bench then checks that a two-operand operation still works on the full stack. All other cases need at most three words, so the small depth hides nothing in the operation set. Shift counts above 31, counts with high bits set beyond the 6-bit field, and mixed-sign compares are each applied directly.

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DEPTH = 16,
  localparam int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] tos,
  output logic [CW-1:0] depth,
  output logic          ovf,
  output logic          unf
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] stk [DEPTH];
  logic [CW-1:0] cnt, ia, ib;
  logic [DW-1:0] a, b, res, rev;
  logic          two, one, full;
  logic          wr_en, cnt_inc, cnt_dec, set_ovf, set_unf;
  logic [CW-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  assign ia   = cnt - 1'b1;
  assign ib   = cnt - 2'd2;
  assign full = (cnt == FULL);
  assign a    = (cnt != '0) ? stk[ia[PW-1:0]] : '0;
  assign b    = (cnt > 1)   ? stk[ib[PW-1:0]] : '0;

  assign tos   = a;
  assign depth = cnt;

  always_comb begin
    for (int j = 0; j < DW; j++) rev[j] = a[DW-1-j];
  end

  always_comb begin
    two = 1'b1;
    one = 1'b0;
    res = '0;
    case (op_code)
      8'h05: res = a + b;
      8'h06: res = a & b;
      8'h07: res = a | b;
      8'h32: res = a ^ b;
      8'h31: res = b - a;
      8'h2E: res = {31'b0, a == b};
      8'h2F: res = {31'b0, a != b};
      8'h24: res = {31'b0, $signed(a) <  $signed(b)};
      8'h25: res = {31'b0, $signed(a) <= $signed(b)};
      8'h26: res = {31'b0, a <  b};
      8'h27: res = {31'b0, a <= b};
      8'h3E: res = a[15:0] * b[15:0];
      8'h2B: res = b << a[5:0];
      8'h2C: res = $unsigned($signed(b) >>> a[5:0]);
      8'h09: begin two = 1'b0; one = 1'b1; res = ~a; end
      8'h30: begin two = 1'b0; one = 1'b1; res = -a; end
      8'h0A: begin two = 1'b0; one = 1'b1; res = rev; end
      8'h28: begin two = 1'b0; one = 1'b1; res = {a[15:0], a[31:16]}; end
      default: two = 1'b0;
    endcase
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cnt;
    wr_data = push_data;
    cnt_inc = 1'b0;
    cnt_dec = 1'b0;
    set_ovf = 1'b0;
    set_unf = 1'b0;
    if (push_valid) begin
      if (full) set_ovf = 1'b1;
      else begin
        wr_en   = 1'b1;
        cnt_inc = 1'b1;
      end
    end else if (op_valid) begin
      if (two) begin
        if (cnt < 2) set_unf = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_idx  = ib;
          wr_data = res;
          cnt_dec = 1'b1;
        end
      end else if (one) begin
        if (cnt == '0) set_unf = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_idx  = ia;
          wr_data = res;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk[wr_idx[PW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (cnt_inc) cnt <= cnt + 1'b1;
      else if (cnt_dec) cnt <= cnt - 1'b1;
      if (set_ovf) ovf <= 1'b1;
      if (set_unf) unf <= 1'b1;
    end
  end

endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [7:0]    op_code,
  input logic          push_valid,
  input logic [31:0]   push_data,
  input logic [31:0]   tos,
  input logic [CW-1:0] depth,
  input logic          ovf,
  input logic          unf
);

  localparam logic [CW-1:0] LIM = CW'(DEPTH);

  logic dyad, mono, act;
  assign dyad = op_code inside {8'h05, 8'h06, 8'h07, 8'h32, 8'h31, 8'h2E, 8'h2F,
                                8'h24, 8'h25, 8'h26, 8'h27, 8'h3E, 8'h2B, 8'h2C};
  assign mono = op_code inside {8'h09, 8'h30, 8'h0A, 8'h28};
  assign act  = op_valid && !push_valid;

  p_depth_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= LIM);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_full_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && depth == LIM |=> ovf && depth == $past(depth) && tos == $past(tos));

  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && depth < LIM |=> depth == $past(depth) + 1'b1 && tos == $past(push_data));

  p_unf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);

  p_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    act && ((dyad && depth < 2) || (mono && depth == '0))
    |=> unf && depth == $past(depth) && tos == $past(tos));

  p_pair_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act && dyad && depth >= 2 |=> depth == $past(depth) - 1'b1);

  p_single_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act && mono && depth != '0 |=> depth == $past(depth));

  p_nop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    act && !dyad && !mono |=> $stable(depth) && $stable(tos) && $stable(ovf) && $stable(unf));

  p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    depth == '0 |-> tos == '0);

endmodule

bind stk_alu stk_alu_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .push_valid(push_valid), .push_data(push_data), .tos(tos),
  .depth(depth), .ovf(ovf), .unf(unf)
);

// File: tb/stk_alu_bench.sv
`timescale 1ns/1ps
module stk_alu_bench;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 0, rst_n = 0;
  logic          op_valid = 0, push_valid = 0;
  logic [7:0]    op_code = '0;
  logic [31:0]   push_data = '0;
  logic [31:0]   tos;
  logic [CW-1:0] depth;
  logic          ovf, unf;
  int vecs = 0, errs = 0;

  always #10 clk = ~clk;

  stk_alu #(.DEPTH(DEPTH)) u_stk_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .push_valid(push_valid), .push_data(push_data), .tos(tos),
    .depth(depth), .ovf(ovf), .unf(unf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 0; op_valid = 0; push_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] v);
    push_valid = 1; push_data = v;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic op(input logic [7:0] c);
    op_valid = 1; op_code = c;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic pair(input string tag, input logic [31:0] bv, input logic [31:0] av,
                      input logic [7:0] c, input logic [31:0] exp);
    reset_dut();
    push(bv); push(av); op(c);
    chk(tag, tos, exp);
    chk({tag, " depth"}, 32'(depth), 32'd1);
  endtask

  task automatic single(input string tag, input logic [31:0] v, input logic [7:0] c,
                        input logic [31:0] exp);
    reset_dut();
    push(v); op(c);
    chk(tag, tos, exp);
    chk({tag, " depth"}, 32'(depth), 32'd1);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 depth", 32'(depth), 0);
    chk("R1 tos", tos, 0);
    chk("R1 flags", {30'b0, ovf, unf}, 0);
    push(32'hCAFE0001);
    chk("R2 push tos", tos, 32'hCAFE0001);
    chk("R2 push depth", 32'(depth), 1);
  endtask

  task automatic t_logic();
    pair("R4 add wrap", 32'hFFFFFFFF, 32'd2, 8'h05, 32'd1);
    pair("R4 and", 32'h0000F0F0, 32'h0000FF00, 8'h06, 32'h0000F000);
    pair("R4 or", 32'h0000F0F0, 32'h0000FF00, 8'h07, 32'h0000FFF0);
    pair("R4 xor", 32'h0000F0F0, 32'h0000FF00, 8'h32, 32'h00000FF0);
  endtask

  task automatic t_sub();
    pair("R5 sub b-a", 32'd10, 32'd3, 8'h31, 32'd7);
    pair("R5 sub negative", 32'd3, 32'd10, 8'h31, 32'hFFFFFFF9);
  endtask

  task automatic t_unary();
    single("R6 invert", 32'h0F0F0000, 8'h09, 32'hF0F0FFFF);
    single("R6 negate", 32'd5, 8'h30, 32'hFFFFFFFB);
  endtask

  task automatic t_bits();
    single("R7 reverse one", 32'h00000001, 8'h0A, 32'h80000000);
    single("R7 reverse word", 32'h12345678, 8'h0A, 32'h1E6A2C48);
    single("R7 halfword swap", 32'h12345678, 8'h28, 32'h56781234);
  endtask

  task automatic t_cmp();
    pair("R8 eq equal", 32'd9, 32'd9, 8'h2E, 32'd1);
    pair("R8 eq differ", 32'd9, 32'd8, 8'h2E, 32'd0);
    pair("R8 ne equal", 32'd9, 32'd9, 8'h2F, 32'd0);
    pair("R9 signed lt", 32'd5, 32'hFFFFFFFF, 8'h24, 32'd1);
    pair("R9 unsigned lt", 32'd5, 32'hFFFFFFFF, 8'h26, 32'd0);
    pair("R9 signed le equal", 32'd7, 32'd7, 8'h25, 32'd1);
    pair("R9 unsigned le false", 32'd3, 32'd4, 8'h27, 32'd0);
    pair("R9 signed le false", 32'hFFFFFFFF, 32'd5, 8'h25, 32'd0);
  endtask

  task automatic t_mult();
    pair("R10 mult16", 32'hABCD0003, 32'h1234FFFF, 8'h3E, 32'h0002FFFD);
  endtask

  task automatic t_shift();
    pair("R11 shl 4", 32'd1, 32'd4, 8'h2B, 32'h10);
    pair("R11 shl masked", 32'd1, 32'h00000044, 8'h2B, 32'h10);
    pair("R11 shl 40", 32'd1, 32'd40, 8'h2B, 32'd0);
    pair("R11 asr 4", 32'h80000000, 32'd4, 8'h2C, 32'hF8000000);
    pair("R11 asr 33", 32'h80000000, 32'd33, 8'h2C, 32'hFFFFFFFF);
    pair("R11 asr 40 positive", 32'h40000000, 32'd40, 8'h2C, 32'd0);
  endtask

  task automatic t_underflow();
    reset_dut();
    op(8'h05);
    chk("R12 empty pair unf", 32'(unf), 1);
    chk("R12 empty pair depth", 32'(depth), 0);
    reset_dut();
    op(8'h09);
    chk("R12 empty single unf", 32'(unf), 1);
    reset_dut();
    push(32'd7);
    op(8'h05);
    chk("R12 one word unf", 32'(unf), 1);
    chk("R12 one word tos", tos, 32'd7);
    chk("R12 one word depth", 32'(depth), 1);
    push(32'd2); op(8'h05);
    chk("R12 sticky after valid op", 32'(unf), 1);
    chk("R12 op after underflow", tos, 32'd9);
  endtask

  task automatic t_overflow();
    reset_dut();
    for (int i = 1; i <= DEPTH; i++) push(32'(i));
    chk("R3 full no flag", 32'(ovf), 0);
    push(32'd99);
    chk("R3 ovf set", 32'(ovf), 1);
    chk("R3 depth held", 32'(depth), DEPTH);
    chk("R3 tos held", tos, 32'(DEPTH));
    op(8'h05);
    chk("R3 op on full", tos, 32'(2 * DEPTH - 1));
    chk("R3 ovf sticky", 32'(ovf), 1);
    chk("R3 unf clear", 32'(unf), 0);
  endtask

  task automatic t_nop();
    reset_dut();
    push(32'h55); push(32'h66);
    op(8'h0B);
    chk("R13 nop tos", tos, 32'h66);
    op(8'h00); op(8'hFF); op(8'h08); op(8'h35);
    chk("R13 unlisted tos", tos, 32'h66);
    chk("R13 unlisted depth", 32'(depth), 2);
    chk("R13 unlisted flags", {30'b0, ovf, unf}, 0);
    op(8'h05);
    chk("R13 contents intact", tos, 32'hBB);
  endtask

  task automatic t_collision();
    reset_dut();
    push(32'd2); push(32'd3);
    push_valid = 1; push_data = 32'd9; op_valid = 1; op_code = 8'h05;
    @(negedge clk);
    push_valid = 0; op_valid = 0;
    chk("R2 collision tos", tos, 32'd9);
    chk("R2 collision depth", 32'(depth), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_logic();
    t_sub();
    t_unary();
    t_bits();
    t_cmp();
    t_mult();
    t_shift();
    t_underflow();
    t_overflow();
    t_nop();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule